// File: doc/BRIEF.md
# Key-Locked Partitioned Save RAM

This block holds 5 KiB of on-chip save RAM that the CPU sees at 0x6000–0x73FF. The RAM index is the CPU address minus 0x6000. The space is cut into three regions of unequal size. Each region has its own 8-bit lock register, and the region can be reached only while that register holds one exact key byte. Every other value keeps the region sealed. Reads from a sealed region, or from any address the block does not serve, do not drive the bus. The block then passes the open-bus byte straight through. Writes to a sealed region are dropped.

The three lock registers can only be written. They sit at consecutive addresses, and the order of the regions follows the order of those addresses. Reads have a fixed latency of one cycle. A read strobe with an address in cycle N gives the data and the drive enable in cycle N+1, after the clock edge. Writes take effect on the clock edge of the cycle that carries the write strobe. Reset relocks every region. It leaves the RAM contents as they were, so stored data survives a reset.

Top module: `keyed_wram`

## Requirements
- R1: Reset (synchronous, active high) clears all three lock registers. After reset every region is locked and rd_drive is 0.
- R2: Region 0 covers 0x6000–0x67FF (2 KiB). It is readable and writable only while the lock register at 0x7EF7 holds 0xCA.
- R3: Region 1 covers 0x6800–0x6FFF (2 KiB). It is readable and writable only while the lock register at 0x7EF8 holds 0x69.
- R4: Region 2 covers 0x7000–0x73FF (1 KiB). It is readable and writable only while the lock register at 0x7EF9 holds 0x84.
- R5: A write into a locked region leaves the stored byte unchanged. The old byte is still there when the region is later unlocked.
- R6: A read from a locked region gives rd_drive = 0 in the next cycle. In that cycle rd_data equals the bus_in byte that was present in the cycle of the read. Whenever rd_drive is 0, rd_data is the bus_in byte from the previous cycle.
- R7: A read of an unlocked region in cycle N gives rd_drive = 1 and the stored byte on rd_data in cycle N+1. rd_drive is 0 in any cycle that follows a cycle with cpu_rd low.
- R8: Writing any non-key value to a lock register relocks its region from the next cycle on. Data stored in that region is kept, and it reads back unchanged once the key is written again.
- R9: Writing a lock register affects only its own region. Unlocking one region leaves the other two locked.
- R10: If cpu_rd and cpu_wr are both high in one cycle at the same unlocked address, the read returns the byte stored before that cycle and the new byte is stored.
- R11: Addresses outside 0x6000–0x73FF are never driven and never change the RAM. The lock registers read as open bus.
- R12: RAM contents are not altered by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, acts on the clock edge |
| cpu_rd | input | 1 | Read strobe, result one cycle later |
| bus_in | input | 8 | Open-bus byte currently on the CPU bus |
| rd_data | output | 8 | Read data, or the open-bus byte when not driving |
| rd_drive | output | 1 | High when the block drives stored data onto the bus |

## Verification
Two functions can fall in the same cycle: a read and a write to one RAM byte, and a lock-register write followed at once by an access that depends on it. The bench provokes the first case by raising both strobes together on an unlocked address and expects the old byte first and the new byte on the next read. It provokes the second case by writing a wrong key and reading on the very next cycle. A randomized stream then mixes both strobes, lock writes with right and wrong keys, and reads across all three regions. A behavioural model updated on every edge judges each cycle's rd_drive and rd_data.

// File: rtl/keyed_wram_pkg.sv
package keyed_wram_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 16;
    localparam int NUM_REGIONS = 3;

    // lock registers sit at consecutive addresses, one per region in order
    localparam logic [ADDR_W-1:0] LOCK_BASE = 16'h7EF7;

    function automatic logic [ADDR_W-1:0] region_lo(input int r);
        case (r)
            0:       return 16'h6000;
            1:       return 16'h6800;
            default: return 16'h7000;
        endcase
    endfunction

    // log2 of the region size in bytes
    function automatic int region_aw(input int r);
        return (r == 2) ? 10 : 11;
    endfunction

    function automatic logic [ADDR_W-1:0] region_hi(input int r);
        return region_lo(r) + ADDR_W'((1 << region_aw(r)) - 1);
    endfunction

    function automatic logic [DATA_W-1:0] region_key(input int r);
        case (r)
            0:       return 8'hCA;
            1:       return 8'h69;
            default: return 8'h84;
        endcase
    endfunction

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cpu_req_t;

    typedef struct packed {
        logic                   drive;
        logic [NUM_REGIONS-1:0] sel;
    } rd_track_t;

endpackage

// File: rtl/wram_addr_decode.sv
module wram_addr_decode
    import keyed_wram_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGIONS
) (
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] region_hit,
    output logic [NR-1:0] lock_hit
);

    for (genvar r = 0; r < NR; r++) begin : g_dec
        assign region_hit[r] = (addr >= region_lo(r)) && (addr <= region_hi(r));
        assign lock_hit[r]   = (addr == LOCK_BASE + AW'(r));
    end

endmodule

// File: rtl/wram_key_gate.sv
module wram_key_gate
    import keyed_wram_pkg::*;
#(
    parameter int                DW  = DATA_W,
    parameter logic [DATA_W-1:0] KEY = 8'hCA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          unlocked
);

    logic [DW-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= '0;
        else if (wr_en)
            lock_q <= wdata;
    end

    assign unlocked = (lock_q == DW'(KEY));

    AST_RESET_LOCKS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !unlocked);                               // R1
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == DW'(KEY)) |=> unlocked);              // R2
    AST_BAD_KEY_SEALS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata != DW'(KEY)) |=> !unlocked);             // R8
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(unlocked));                           // R9

endmodule

// File: rtl/wram_bank.sv
module wram_bank
    import keyed_wram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read-before-write: rdata carries the byte stored before this edge
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/keyed_wram.sv
module keyed_wram
    import keyed_wram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    cpu_req_t               req;
    logic [NUM_REGIONS-1:0] region_hit;
    logic [NUM_REGIONS-1:0] lock_hit;
    logic [NUM_REGIONS-1:0] unlocked;
    logic [NUM_REGIONS-1:0] open_hit;
    logic [DATA_W-1:0]      bank_q [NUM_REGIONS];
    logic [DATA_W-1:0]      bus_q;
    rd_track_t              track_q;

    assign req = '{rd: cpu_rd, wr: cpu_wr, addr: cpu_addr, wdata: cpu_wdata};

    wram_addr_decode #(.AW(ADDR_W), .NR(NUM_REGIONS)) u_dec (
        .addr       (req.addr),
        .region_hit (region_hit),
        .lock_hit   (lock_hit)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam int RAW = region_aw(r);

        wram_key_gate #(.DW(DATA_W), .KEY(region_key(r))) u_gate (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (!rst && req.wr && lock_hit[r]),
            .wdata    (req.wdata),
            .unlocked (unlocked[r])
        );

        wram_bank #(.AW(RAW), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .we    (!rst && req.wr && region_hit[r] && unlocked[r]),
            .addr  (req.addr[RAW-1:0]),
            .wdata (req.wdata),
            .rdata (bank_q[r])
        );
    end

    assign open_hit = region_hit & unlocked;

    // open-bus byte follows the bus one cycle late, matching read latency
    always_ff @(posedge clk) begin
        bus_q <= bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            track_q <= '0;
        end else begin
            track_q.drive <= req.rd && (|open_hit);
            track_q.sel   <= open_hit;
        end
    end

    always_comb begin
        rd_data = bus_q;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (track_q.drive && track_q.sel[r])
                rd_data = bank_q[r];
        end
    end

    assign rd_drive = track_q.drive;

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> $past(cpu_rd));                                        // R7
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> !rd_drive);                                             // R7
    AST_SEALED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !(|open_hit)) |=> !rd_drive);                            // R6
    AST_OPEN_BUS_PASS: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> (rd_data == $past(bus_in)));                          // R6
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && (cpu_addr < 16'h6000 || cpu_addr > 16'h73FF)) |=> !rd_drive); // R11

endmodule

// File: tb/sim_keyed_wram.sv
`timescale 1ns/1ps
module sim_keyed_wram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  rd_data;
    logic        rd_drive;

    always #5 clk = ~clk;

    keyed_wram u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .bus_in(bus_in),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    int    total = 0;
    int    fails = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // reference model
    int mem [5120];
    int keys [3];
    int key_val [3] = '{32'hCA, 32'h69, 32'h84};
    bit exp_drive = 1'b0;
    int exp_data = -1;
    bit exp_valid = 1'b0;

    function automatic int region_of(input logic [15:0] a);
        if (a >= 16'h6000 && a <= 16'h67FF) return 0;
        if (a >= 16'h6800 && a <= 16'h6FFF) return 1;
        if (a >= 16'h7000 && a <= 16'h73FF) return 2;
        return -1;
    endfunction

    initial begin
        for (int i = 0; i < 5120; i++) mem[i] = -1;
        for (int i = 0; i < 3; i++) keys[i] = 0;
    end

    always @(posedge clk) begin
        int  reg_i;
        bit  ok;
        exp_tag   = cur_tag;
        exp_valid = 1'b1;
        if (rst) begin
            for (int i = 0; i < 3; i++) keys[i] = 0;
            exp_drive = 1'b0;
            exp_data  = int'(bus_in);
        end else begin
            reg_i = region_of(cpu_addr);
            ok = (reg_i >= 0) && (keys[reg_i] == key_val[reg_i]);
            exp_drive = cpu_rd && ok;
            exp_data  = exp_drive ? mem[int'(cpu_addr) - 32'h6000] : int'(bus_in);
            if (cpu_wr) begin
                if (ok) mem[int'(cpu_addr) - 32'h6000] = int'(cpu_wdata);
                if (cpu_addr >= 16'h7EF7 && cpu_addr <= 16'h7EF9)
                    keys[int'(cpu_addr) - 32'h7EF7] = int'(cpu_wdata);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle of stimulus, then compare outputs against the model
    task automatic cyc(input logic r, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic [7:0] b, input string tag);
        cpu_rd = r; cpu_wr = w; cpu_addr = a; cpu_wdata = d; bus_in = b; cur_tag = tag;
        @(negedge clk);
        if (exp_valid) begin
            chk(rd_drive === exp_drive, exp_tag, int'(rd_drive), int'(exp_drive));
            if (exp_data >= 0)
                chk(rd_data === exp_data[7:0], exp_tag, int'(rd_data), exp_data);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        cyc(1'b0, 1'b1, a, d, 8'h00, tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] b, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00, b, tag);
    endtask

    task automatic expect_out(input bit drv, input logic [7:0] data, input string tag);
        chk(rd_drive === drv, tag, int'(rd_drive), int'(drv));
        chk(rd_data === data, tag, int'(rd_data), int'(data));
    endtask

    initial begin
        #1_000_000;
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(0, 0, 16'h0000, 8'h00, 8'hA5, "R1");
        cyc(0, 0, 16'h0000, 8'h00, 8'h5A, "R1");
        rst = 1'b0;
        cyc(0, 0, 16'h0000, 8'h00, 8'h00, "R1");
        chk(rd_drive === 1'b0, "R1", int'(rd_drive), 0);
        rd(16'h6000, 8'hB7, "R1");                 expect_out(0, 8'hB7, "R1");

        // region 0 unlock and bounds
        wr(16'h7EF7, 8'hCA, "R2");
        wr(16'h6000, 8'h5A, "R2");
        rd(16'h6000, 8'h00, "R2");                 expect_out(1, 8'h5A, "R2");
        wr(16'h67FF, 8'hC3, "R2");
        rd(16'h67FF, 8'h00, "R2");                 expect_out(1, 8'hC3, "R2");

        // relock, dropped write, retention
        wr(16'h7EF7, 8'hCB, "R8");
        rd(16'h6000, 8'hF0, "R8");                 expect_out(0, 8'hF0, "R8");
        wr(16'h6000, 8'h11, "R5");
        wr(16'h7EF7, 8'hCA, "R5");
        rd(16'h6000, 8'h00, "R5");                 expect_out(1, 8'h5A, "R5");

        // independence
        rd(16'h6800, 8'h3C, "R9");                 expect_out(0, 8'h3C, "R9");
        rd(16'h7000, 8'h4D, "R9");                 expect_out(0, 8'h4D, "R9");

        // region 1
        wr(16'h7EF8, 8'h68, "R3");
        rd(16'h6800, 8'h21, "R3");                 expect_out(0, 8'h21, "R3");
        wr(16'h7EF8, 8'h69, "R3");
        wr(16'h6800, 8'h77, "R3");
        rd(16'h6800, 8'h00, "R3");                 expect_out(1, 8'h77, "R3");
        wr(16'h6FFF, 8'h88, "R3");
        rd(16'h6FFF, 8'h00, "R3");                 expect_out(1, 8'h88, "R3");

        // region 2
        wr(16'h7EF9, 8'h84, "R4");
        wr(16'h7000, 8'hDD, "R4");
        rd(16'h7000, 8'h00, "R4");                 expect_out(1, 8'hDD, "R4");
        wr(16'h73FF, 8'hEE, "R4");
        rd(16'h73FF, 8'h00, "R4");                 expect_out(1, 8'hEE, "R4");

        // outside the RAM window
        wr(16'h7400, 8'h12, "R11");
        rd(16'h7400, 8'h99, "R11");                expect_out(0, 8'h99, "R11");
        rd(16'h7EF9, 8'h6A, "R11");                expect_out(0, 8'h6A, "R11");
        rd(16'h5FFF, 8'h6B, "R11");                expect_out(0, 8'h6B, "R11");
        rd(16'h73FF, 8'h00, "R11");                expect_out(1, 8'hEE, "R11");

        // read and write in the same cycle
        wr(16'h6010, 8'h33, "R10");
        cyc(1, 1, 16'h6010, 8'h44, 8'h00, "R10");  expect_out(1, 8'h33, "R10");
        rd(16'h6010, 8'h00, "R10");                expect_out(1, 8'h44, "R10");

        // latency: back-to-back reads, then idle
        rd(16'h6000, 8'h00, "R7");                 expect_out(1, 8'h5A, "R7");
        rd(16'h6800, 8'h00, "R7");                 expect_out(1, 8'h77, "R7");
        cyc(0, 0, 16'h6800, 8'h00, 8'h2E, "R7");   expect_out(0, 8'h2E, "R7");

        // locked read: open bus byte from the read cycle
        wr(16'h7EF9, 8'h00, "R6");
        rd(16'h7000, 8'hC1, "R6");                 expect_out(0, 8'hC1, "R6");

        // reset keeps RAM, relocks all
        rst = 1'b1;
        cyc(0, 0, 16'h0000, 8'h00, 8'h00, "R12");
        cyc(0, 0, 16'h0000, 8'h00, 8'h00, "R12");
        rst = 1'b0;
        rd(16'h6000, 8'h1F, "R1");                 expect_out(0, 8'h1F, "R1");
        rd(16'h6800, 8'h2F, "R1");                 expect_out(0, 8'h2F, "R1");
        wr(16'h7EF7, 8'hCA, "R12");
        rd(16'h6000, 8'h00, "R12");                expect_out(1, 8'h5A, "R12");
        wr(16'h7EF8, 8'h69, "R12");
        rd(16'h6FFF, 8'h00, "R12");                expect_out(1, 8'h88, "R12");

        // randomized mix against the model
        for (int i = 0; i < 600; i++) begin
            int          k;
            int          r;
            logic [15:0] a;
            k = int'($urandom % 8);
            r = int'($urandom % 3);
            a = 16'h6000 + 16'(r * 16'h0800) + 16'($urandom % 6);
            case (k)
                0, 1: cyc(0, 1, a, 8'($urandom), 8'($urandom), "R8");
                2, 3, 4: cyc(1, 0, a, 8'h00, 8'($urandom), "R8");
                5: cyc(0, 1, 16'h7EF7 + 16'(r), 8'(key_val[r]), 8'($urandom), "R8");
                6: cyc(0, 1, 16'h7EF7 + 16'(r), 8'($urandom), 8'($urandom), "R8");
                default: cyc(1, 1, a, 8'($urandom), 8'($urandom), "R10");
            endcase
        end
        cyc(0, 0, 16'h0000, 8'h00, 8'h00, "R7");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule